// File: doc/BRIEF.md
# Dual Prescaled Down-Counter Timer

This peripheral holds two independent timer channels on one APB slave port. Each channel has a down counter that is `CW` bits wide (16 by default) and runs freely from a shared timer clock. It reloads itself after reaching zero, raises a maskable interrupt and drives a PWM output from a compare threshold. All logic runs on the bus clock. The timer clock is an enable pulse in that domain. It comes either from the bus clock divided by two or from a slow external reference of 32.768 kHz, which passes through a synchroniser and an edge detector.

One chain of two divide-by-16 stages supplies three tick taps: undivided, /16 and /256. Each channel picks its own tap. Software programs a start value, a compare value and a control word, and acknowledges interrupts through a write-only clear register. It can read the live count and the raw flag at any time.

Top module: `dual_tick_timer`

## Requirements
- R1: After reset, every load, compare, control, count and flag register holds zero. Both `irq` bits are 0. Both `pwm` bits are 1, because a count of 0 is at or below a compare value of 0.
- R2: A channel's count drops by one on each of its ticks while its enable bit (control bit 0) is 1. The count holds while the enable bit is 0 or no tick occurs.
- R3: On a tick at count zero, the counter takes the load register value, so one period spans load+1 ticks.
- R4: The raw flag (status register bit 0) is set by any tick whose new count is zero. If a clear write falls in the same cycle, the set wins.
- R5: Writing the clear register with bit 0 = 1 drops the flag on the next edge. Writing it with bit 0 = 0 leaves the flag unchanged.
- R6: `irq[i]` is the channel's flag ANDed with its mask bit (control bit 3).
- R7: A write to the load register sets both the load register and the counter to `pwdata[CW-1:0]` on that edge. This write overrides a tick in the same cycle and does not set the flag.
- R8: With `clk_src_slow` = 0, the timer clock ticks on every second bus clock. Counting starts from a phase bit that is 0 after reset and toggles on every cycle.
- R9: With `clk_src_slow` = 1, `ref_clk` passes through two flops, and each rising edge gives a timer tick lasting one bus cycle. That tick falls three bus edges after `ref_clk` is sampled high.
- R10: Control bits 2:1 select the tap. 0 gives the timer clock itself, 1 gives every 16th timer tick, and 2 or 3 give every 256th. Both channels share the prescaler.
- R11: `pwm[i]` is 1 while the count is less than or equal to the compare value, and 0 otherwise.
- R12: The register map uses word offsets load 0x00, value 0x04 (read-only), control 0x08, clear 0x0C (write-only, reads 0), status 0x10 (read-only) and compare 0x14. Channel 1 sits at these offsets plus 0x20. Any address with bits above bit 5 set reads 0 and has no effect on writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock |
| presetn | input | 1 | Active-low reset |
| clk_src_slow | input | 1 | 1 selects the slow reference as the timer clock |
| ref_clk | input | 1 | Asynchronous 32.768 kHz reference |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write strobe |
| paddr | input | AW | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| irq | output | 2 | Masked interrupt per channel |
| pwm | output | 2 | Compare-driven PWM per channel |

## Verification
Two events can land on the same edge, and the bench aims at both. In the first, the tick that sets a flag falls in the same cycle as a software clear. In the second, a load write arrives in the same cycle as a counting tick. Clear and load writes are issued back-to-back with idle gaps that rotate between 0 and 3 cycles, so their phase sweeps past the channel's short period and produces both collisions. A behavioural model decides which action wins: a set beats a clear, and a load beats a tick. The model is compared against `irq`, `pwm` and register reads on every cycle.

// File: rtl/dual_tick_timer.sv
module dual_tick_timer #(
  parameter int CW = 16,
  parameter int AW = 8
) (
  input  logic          pclk,
  input  logic          presetn,
  input  logic          clk_src_slow,
  input  logic          ref_clk,
  input  logic          psel,
  input  logic          penable,
  input  logic          pwrite,
  input  logic [AW-1:0] paddr,
  input  logic [31:0]   pwdata,
  output logic [31:0]   prdata,
  output logic [1:0]    irq,
  output logic [1:0]    pwm
);
  localparam int PW = 4;
  localparam logic [PW-1:0] PMAX = '1;

  logic [1:0][CW-1:0] cnt, ld, cmp, nxt;
  logic [1:0][1:0]    sel;
  logic [1:0]         en, mask, flag, tick, wr_ld, wr_ctl, wr_clr, wr_cmp;
  logic [PW-1:0]      pa, pb;
  logic               div2, s0, s1, s2, base_tick, t16, t256;

  wire wr_any = psel & penable & pwrite & (paddr[AW-1:6] == '0);
  wire [2:0] off = paddr[4:2];
  wire unused_bits = ^{pwdata[31:CW], paddr[1:0]};

  always_ff @(posedge pclk or negedge presetn)
    if (!presetn) {div2, s0, s1, s2} <= '0;
    else {div2, s0, s1, s2} <= {~div2, ref_clk, s0, s1};

  assign base_tick = clk_src_slow ? (s1 & ~s2) : div2;
  assign t16  = base_tick & (pa == PMAX);
  assign t256 = t16 & (pb == PMAX);

  always_ff @(posedge pclk or negedge presetn)
    if (!presetn) begin
      pa <= '0;
      pb <= '0;
    end else begin
      if (base_tick) pa <= pa + 1'b1;
      if (t16)       pb <= pb + 1'b1;
    end

  for (genvar i = 0; i < 2; i++) begin : g_ch
    wire hit = wr_any & (paddr[5] == 1'(i));
    assign wr_ld[i]  = hit & (off == 3'd0);
    assign wr_ctl[i] = hit & (off == 3'd2);
    assign wr_clr[i] = hit & (off == 3'd3) & pwdata[0];
    assign wr_cmp[i] = hit & (off == 3'd5);
    assign tick[i] = en[i] & (sel[i] == 2'd0 ? base_tick :
                              sel[i] == 2'd1 ? t16 : t256);
    assign nxt[i] = (cnt[i] == '0) ? ld[i] : cnt[i] - 1'b1;

    always_ff @(posedge pclk or negedge presetn)
      if (!presetn) begin
        cnt[i] <= '0; ld[i] <= '0; cmp[i] <= '0; flag[i] <= 1'b0;
        en[i] <= 1'b0; sel[i] <= 2'd0; mask[i] <= 1'b0;
      end else begin
        if (wr_ld[i]) begin
          ld[i]  <= pwdata[CW-1:0];
          cnt[i] <= pwdata[CW-1:0];
        end else if (tick[i]) begin
          cnt[i] <= nxt[i];
        end
        if (tick[i] && !wr_ld[i] && nxt[i] == '0) flag[i] <= 1'b1;
        else if (wr_clr[i])                        flag[i] <= 1'b0;
        if (wr_ctl[i]) {mask[i], sel[i], en[i]} <= pwdata[3:0];
        if (wr_cmp[i]) cmp[i] <= pwdata[CW-1:0];
      end

    assign irq[i] = flag[i] & mask[i];
    assign pwm[i] = cnt[i] <= cmp[i];

    p_flag_set_r4: assert property (@(posedge pclk) disable iff (!presetn)
      tick[i] && !wr_ld[i] && nxt[i] == '0 |=> flag[i]);
    p_clear_r5: assert property (@(posedge pclk) disable iff (!presetn)
      wr_clr[i] && !(tick[i] && nxt[i] == '0) |=> !flag[i]);
    p_load_r7: assert property (@(posedge pclk) disable iff (!presetn)
      wr_ld[i] |=> cnt[i] == $past(pwdata[CW-1:0]));
    p_hold_r2: assert property (@(posedge pclk) disable iff (!presetn)
      !tick[i] && !wr_ld[i] |=> $stable(cnt[i]));
  end

  p_fast_half_r8: assert property (@(posedge pclk) disable iff (!presetn)
    !clk_src_slow && base_tick |=> clk_src_slow || !base_tick);
  p_slow_pulse_r9: assert property (@(posedge pclk) disable iff (!presetn)
    clk_src_slow && base_tick |=> !clk_src_slow || !base_tick);
  p_tap_nest_r10: assert property (@(posedge pclk) disable iff (!presetn)
    t256 |-> t16 && base_tick);

  always_comb begin
    logic c;
    c = paddr[5];
    prdata = '0;
    if (paddr[AW-1:6] == '0)
      case (off)
        3'd0: prdata = 32'(ld[c]);
        3'd1: prdata = 32'(cnt[c]);
        3'd2: prdata = {28'd0, mask[c], sel[c], en[c]};
        3'd4: prdata = {31'd0, flag[c]};
        3'd5: prdata = 32'(cmp[c]);
        default: prdata = '0;
      endcase
  end
endmodule

// File: tb/dual_tick_timer_test.sv
module dual_tick_timer_test;
  localparam int PERIOD = 10;
  logic clk = 0, presetn = 0, src = 0, refc = 0;
  logic psel = 0, penable = 0, pwrite = 0;
  logic [7:0] paddr = 0;
  logic [31:0] pwdata = 0;
  logic [31:0] prdata;
  logic [1:0] irq, pwm;
  int checks = 0, fails = 0, refhalf = 0, refcnt = 0;
  bit done = 0;
  int m_cnt[2], m_ld[2], m_cmp[2], m_en[2], m_sel[2], m_mask[2], m_flag[2];
  int div2, s0, s1, s2, pa, pb;

  dual_tick_timer uut (.pclk(clk), .presetn(presetn), .clk_src_slow(src), .ref_clk(refc),
    .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata),
    .prdata(prdata), .irq(irq), .pwm(pwm));

  always #(PERIOD/2) clk = ~clk;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int mread(int ch, int off);
    case (off)
      0: return m_ld[ch];
      1: return m_cnt[ch];
      2: return m_en[ch] | (m_sel[ch] << 1) | (m_mask[ch] << 3);
      4: return m_flag[ch];
      5: return m_cmp[ch];
      default: return 0;
    endcase
  endfunction

  task automatic model_adv();
    int base, t16, t256, wr, ch, off;
    int nc[2], nf[2];
    base = src ? (s1 && !s2) : div2;
    t16 = base && pa == 15;
    t256 = t16 && pb == 15;
    wr = psel && penable && pwrite && paddr[7:6] == 0;
    ch = paddr[5];
    off = paddr[4:2];
    for (int i = 0; i < 2; i++) begin
      int tk;
      tk = m_en[i] && (m_sel[i] == 0 ? base : m_sel[i] == 1 ? t16 : t256);
      nc[i] = m_cnt[i];
      nf[i] = m_flag[i];
      if (wr && ch == i && off == 3 && pwdata[0]) nf[i] = 0;
      if (wr && ch == i && off == 0) nc[i] = pwdata[15:0];
      else if (tk) begin
        nc[i] = (m_cnt[i] == 0) ? m_ld[i] : m_cnt[i] - 1;
        if (nc[i] == 0) nf[i] = 1;
      end
    end
    for (int i = 0; i < 2; i++) begin
      m_cnt[i] = nc[i];
      m_flag[i] = nf[i];
      if (wr && ch == i) begin
        if (off == 0) m_ld[i] = pwdata[15:0];
        if (off == 2) begin
          m_en[i] = pwdata[0]; m_sel[i] = pwdata[2:1]; m_mask[i] = pwdata[3];
        end
        if (off == 5) m_cmp[i] = pwdata[15:0];
      end
    end
    if (base) pa = (pa + 1) % 16;
    if (t16) pb = (pb + 1) % 16;
    div2 ^= 1;
    s2 = s1; s1 = s0; s0 = refc;
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    model_adv();
    for (int i = 0; i < 2; i++) begin
      check("R6 irq", 32'(irq[i]), 32'(m_flag[i] && m_mask[i]));
      check("R11 pwm", 32'(pwm[i]), 32'(m_cnt[i] <= m_cmp[i]));
    end
    if (refhalf > 0 && ++refcnt >= refhalf) begin
      refcnt = 0;
      refc = ~refc;
    end
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) step();
  endtask

  task automatic wr(int ch, int off, int data);
    paddr = 8'(ch * 32 + off * 4); pwdata = data; pwrite = 1; psel = 1; penable = 0;
    step();
    penable = 1;
    step();
    psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic rd(int ch, int off, string tag);
    paddr = 8'(ch * 32 + off * 4); pwrite = 0; psel = 1; penable = 0;
    step();
    penable = 1;
    #1;
    check(tag, prdata, 32'(mread(ch, off)));
    step();
    psel = 0; penable = 0;
  endtask

  task automatic rd_all(string tag);
    for (int c = 0; c < 2; c++) for (int o = 0; o < 6; o++) rd(c, o, tag);
  endtask

  initial begin
    for (int i = 0; i < 2; i++) begin
      m_cnt[i] = 0; m_ld[i] = 0; m_cmp[i] = 0; m_en[i] = 0;
      m_sel[i] = 0; m_mask[i] = 0; m_flag[i] = 0;
    end
    {div2, s0, s1, s2, pa, pb} = '0;
    repeat (3) @(posedge clk);
    #1 presetn = 1;
    check("R1 irq", 32'(irq), 0);
    check("R1 pwm", 32'(pwm), 3);
    rd_all("R1 reset regs");
    // R12: high address bits ignored on writes and read 0
    wr(4, 0, 16'h55);
    rd(0, 0, "R12 alias");
    paddr = 8'h40; psel = 1; step(); penable = 1; #1;
    check("R12 high addr read", prdata, 0);
    step(); psel = 0; penable = 0;
    // R2 R3 R8: fast clock, no prescale
    wr(0, 0, 5); wr(0, 5, 2); wr(0, 2, 4'b1001);
    for (int k = 0; k < 10; k++) begin idle(3); rd(0, 1, "R2 R3 R8 count"); end
    rd(0, 4, "R4 flag");
    wr(0, 3, 0); rd(0, 4, "R5 clear bit0=0 ignored");
    wr(0, 3, 1); rd(0, 4, "R5 clear");
    // R5 R4: clear/set collision sweep
    wr(0, 0, 2);
    for (int k = 0; k < 60; k++) begin wr(0, 3, 1); idle(k % 4); end
    rd(0, 4, "R4 set beats clear");
    // R7: load writes against ticks
    for (int k = 0; k < 30; k++) begin wr(0, 0, k % 3); idle(k % 4); rd(0, 1, "R7 load"); end
    // R6: mask off
    wr(0, 2, 4'b0001); idle(20); rd(0, 4, "R6 raw flag with mask off");
    // R2: disable holds
    wr(0, 2, 0); rd(0, 1, "R2 hold"); idle(9); rd(0, 1, "R2 hold");
    // R10: /16 and /256 taps
    wr(1, 0, 3); wr(1, 5, 1); wr(1, 2, 4'b1011);
    for (int k = 0; k < 12; k++) begin idle(25); rd(1, 1, "R10 div16"); end
    wr(0, 0, 1); wr(0, 5, 0); wr(0, 2, 4'b1101);
    for (int k = 0; k < 10; k++) begin idle(300); rd(0, 1, "R10 div256"); end
    wr(0, 2, 4'b1111); idle(1200); rd(0, 1, "R10 sel3");
    // R9: slow source through synchroniser
    wr(0, 2, 4'b1001); wr(1, 2, 4'b1001); wr(1, 0, 4); wr(1, 5, 0);
    src = 1; refhalf = 3;
    for (int k = 0; k < 20; k++) begin idle(5); rd(1, 1, "R9 slow tick"); rd(0, 1, "R9 slow tick"); end
    refhalf = 7;
    for (int k = 0; k < 10; k++) begin idle(11); rd(1, 4, "R9 flag"); end
    src = 0; refhalf = 0;
    idle(30);
    rd_all("R12 final regs");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(PERIOD * 190000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule